// File: doc/BRIEF.md
# I2C Repeated Start Generator with Collision Detection

This block is the part of an I2C bus master that produces a Repeated Start condition on the two open-drain lines. It works through three timed phases, each as long as the 7-bit reload value gives. First SDA is released while SCL is still held low. Next SCL is released and, once it reads high, both lines rest high for a phase. Then SDA is pulled low while SCL is high, and at the end of that phase SCL is pulled low.

While the sequence runs, the block reads back both lines through a two-flop synchronizer. It stops when another master on the bus is sending a '0' or a '1'. When it stops, it releases both lines and raises a sticky collision flag, which software clears.

A finished sequence leaves both lines pulled low, ready for the address byte, and gives a one-cycle completion pulse. A request that arrives while the block is busy has no effect.

Top module: `i2c_rstart_gen`

## Requirements
- R1: After reset, sda_pull, scl_pull, done_pulse, coll_flag and busy are all 0.
- R2: A request accepted while idle starts the sequence. For the first L cycles SDA is released (sda_pull=0) and SCL is pulled low (scl_pull=1). L is the reload value, or 1 when the reload value is 0.
- R3: Next both lines are released. SCL is read through a two-stage synchronizer, and once it reads high the block holds both lines released for L more cycles. With a line that follows at once, both lines are released for L+3 cycles in total.
- R4: If the hold phase ends without collision, the block pulls SDA low with SCL released for L cycles. It then pulls both lines low and raises done_pulse for exactly one cycle, 3L+3 cycles after the cycle of acceptance. Both pulls stay asserted afterwards.
- R5: If SDA reads low when SCL is first seen high, this is a collision: coll_flag sets, both lines are released, busy falls, and no done_pulse follows. With SDA already low at the request, the flag shows L+3 cycles after acceptance.
- R6: A falling edge on SCL during the hold phase, when the block is not pulling SDA, is a collision with the same effects as in R5.
- R7: SDA falling low during the hold phase is not a collision; the sequence completes with the timing of R4.
- R8: coll_flag stays set until coll_clear is asserted; coll_clear lowers it one cycle later.
- R9: start_req while busy is ignored; the running sequence keeps its timing and gives a single done_pulse.
- R10: A reload value of 0 gives phases of one cycle, so completion comes 6 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Request a Repeated Start |
| reload | input | RELOAD_W | Phase length in cycles (0 means 1) |
| coll_clear | input | 1 | Clears the collision flag |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| done_pulse | output | 1 | One-cycle pulse on clean completion |
| coll_flag | output | 1 | Sticky bus-collision flag |
| busy | output | 1 | Sequence in progress |

## Verification
The bench uses the default parameters, RELOAD_W=7 and SYNC_STAGES=2, so the 128 reload values can all be swept, zero included. For each one it counts the cycles spent in every line pattern and the latency to the completion pulse, and compares them with L, L+3 and 3L+3. A modelled second master holds SDA low, pulls SCL low in the middle of the hold, or drops SDA during the hold, which brings both collision kinds and the harmless SDA fall within reach at small and full-scale reload values.

// File: rtl/rstart_pkg.sv
package rstart_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SDA_REL,
    PH_SCL_WAIT,
    PH_HOLD,
    PH_SDA_LOW
  } phase_t;

  // Length in cycles of one timed phase: a zero reload still takes one cycle (R10)
  function automatic int unsigned phase_len(input int unsigned rl);
    return (rl == 0) ? 1 : rl;
  endfunction
endpackage

// File: rtl/rstart_sync.sv
module rstart_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fell
);
  logic [STAGES-1:0] sr;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;

  assign lvl  = sr[STAGES-1];
  assign fell = prev & ~lvl;
endmodule

// File: rtl/rstart_timer.sv
module rstart_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         abort,
  output logic         expire
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (abort)      cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;

  assign expire = (cnt == W'(1));

  // Counting steps down by exactly one per cycle when left alone
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !abort && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rstart_fsm.sv
module rstart_fsm
  import rstart_pkg::*;
#(
  parameter int RW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [RW-1:0] reload,
  input  logic          coll_clear,
  input  logic          sda_lvl,
  input  logic          sda_fell,
  input  logic          scl_lvl,
  input  logic          scl_fell,
  input  logic          tmr_expire,
  output logic          tmr_load,
  output logic [RW-1:0] tmr_val,
  output logic          tmr_abort,
  output logic          sda_pull,
  output logic          scl_pull,
  output logic          done_pulse,
  output logic          coll_flag,
  output logic          busy
);
  localparam int SW = $clog2(SYNC_STAGES + 1);

  phase_t        state, state_nx;
  logic [SW-1:0] settle;
  logic          accept, settled, coll_zero, coll_one, coll_evt;
  logic          rel_done, hold_done, low_done, wait_ok;

  // Named internal events
  assign accept    = (state == PH_IDLE) && start_req;
  assign settled   = (settle == '0);
  assign coll_zero = (state == PH_SCL_WAIT) && settled && scl_lvl && !sda_lvl;
  assign wait_ok   = (state == PH_SCL_WAIT) && settled && scl_lvl && sda_lvl;
  assign coll_one  = (state == PH_HOLD) && scl_fell && !sda_pull;
  assign coll_evt  = coll_zero | coll_one;
  assign rel_done  = (state == PH_SDA_REL) && tmr_expire;
  assign hold_done = (state == PH_HOLD) && tmr_expire && !coll_one;
  assign low_done  = (state == PH_SDA_LOW) && tmr_expire;

  assign tmr_val   = RW'(phase_len(32'(reload)));
  assign tmr_load  = accept | wait_ok | hold_done;
  assign tmr_abort = coll_evt;
  assign busy      = (state != PH_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE:     if (accept)    state_nx = PH_SDA_REL;
      PH_SDA_REL:  if (rel_done)  state_nx = PH_SCL_WAIT;
      PH_SCL_WAIT: if (coll_zero) state_nx = PH_IDLE;
                   else if (wait_ok) state_nx = PH_HOLD;
      PH_HOLD:     if (coll_one)  state_nx = PH_IDLE;
                   else if (hold_done) state_nx = PH_SDA_LOW;
      PH_SDA_LOW:  if (low_done)  state_nx = PH_IDLE;
      default:                    state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= PH_IDLE;
    else        state <= state_nx;

  // Wait for the synchronizer to catch up after SCL is released
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  settle <= '0;
    else if (rel_done)           settle <= SW'(SYNC_STAGES);
    else if (settle != '0)       settle <= settle - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_pull   <= 1'b0;
      scl_pull   <= 1'b0;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (coll_evt) begin
        sda_pull <= 1'b0;
        scl_pull <= 1'b0;
      end else if (accept) begin
        sda_pull <= 1'b0;
        scl_pull <= 1'b1;
      end else if (rel_done) begin
        scl_pull <= 1'b0;
      end else if (hold_done) begin
        sda_pull <= 1'b1;
      end else if (low_done) begin
        scl_pull   <= 1'b1;
        done_pulse <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          coll_flag <= 1'b0;
    else if (coll_evt)   coll_flag <= 1'b1;
    else if (coll_clear) coll_flag <= 1'b0;

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);
  assert_done_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (sda_pull && scl_pull && !busy));
  assert_coll_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> (!sda_pull && !scl_pull && !busy && coll_flag && !done_pulse));
  assert_hold_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HOLD) |-> (!sda_pull && !scl_pull));
  assert_sda_fall_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_HOLD) && sda_fell && !scl_fell && !coll_flag) |=> !coll_flag);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !coll_clear) |=> coll_flag);
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_req && !coll_evt && !low_done) |=> busy);
endmodule

// File: rtl/i2c_rstart_gen.sv
module i2c_rstart_gen #(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                coll_clear,
  input  logic                sda_in,
  input  logic                scl_in,
  output logic                sda_pull,
  output logic                scl_pull,
  output logic                done_pulse,
  output logic                coll_flag,
  output logic                busy
);
  logic sda_lvl, sda_fell, scl_lvl, scl_fell;
  logic tmr_load, tmr_abort, tmr_expire;
  logic [RELOAD_W-1:0] tmr_val;

  rstart_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .pin(sda_in), .lvl(sda_lvl), .fell(sda_fell));

  rstart_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .pin(scl_in), .lvl(scl_lvl), .fell(scl_fell));

  rstart_timer #(.W(RELOAD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .abort(tmr_abort), .expire(tmr_expire));

  rstart_fsm #(.RW(RELOAD_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload(reload),
    .coll_clear(coll_clear), .sda_lvl(sda_lvl), .sda_fell(sda_fell),
    .scl_lvl(scl_lvl), .scl_fell(scl_fell), .tmr_expire(tmr_expire),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_abort(tmr_abort),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .done_pulse(done_pulse),
    .coll_flag(coll_flag), .busy(busy));
endmodule

// File: tb/i2c_rstart_gen_test.sv
module i2c_rstart_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int RW         = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_req = 1'b0;
  logic [RW-1:0] reload = '0;
  logic          coll_clear = 1'b0;
  logic          sda_pull, scl_pull, done_pulse, coll_flag, busy;
  logic          oth_sda = 1'b0, oth_scl = 1'b0;
  logic          sda_line, scl_line;
  int            total = 0, bad = 0;

  assign sda_line = !(sda_pull || oth_sda);
  assign scl_line = !(scl_pull || oth_scl);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rstart_gen #(.RELOAD_W(RW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload(reload),
    .coll_clear(coll_clear), .sda_in(sda_line), .scl_in(scl_line),
    .sda_pull(sda_pull), .scl_pull(scl_pull), .done_pulse(done_pulse),
    .coll_flag(coll_flag), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // mode 0 plain, 1 SDA held low, 2 SCL pulled mid-hold, 3 SDA drop mid-hold, 4 extra request
  task automatic run(input int n, input int mode);
    int len = (n == 0) ? 1 : n;
    int c = 0, pa = 0, pb = 0, pc = 0, dones = 0, done_at = -1, coll_at = -1;
    @(negedge clk);
    reload = RW'(n);
    start_req = 1'b1;
    if (mode == 1) oth_sda = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_req = 1'b0;
    while (c < 3*len + 10) begin
      if (busy && !sda_pull && scl_pull)  pa++;
      if (busy && !sda_pull && !scl_pull) pb++;
      if (busy && sda_pull && !scl_pull)  pc++;
      if (done_pulse) begin dones++; if (done_at < 0) done_at = c; end
      if (coll_flag && coll_at < 0) coll_at = c;
      if (mode == 2 && c == len + 4) oth_scl = 1'b1;
      if (mode == 3 && c == len + 4) oth_sda = 1'b1;
      if (mode == 4 && c == 2) start_req = 1'b1;
      if (mode == 4 && c == 3) start_req = 1'b0;
      @(posedge clk);
      c++;
      @(negedge clk);
    end
    case (mode)
      0, 3, 4: begin
        chk(mode == 3 ? "R7 done latency" : (n == 0 ? "R10 done latency" : "R4 done latency"),
            done_at, 3*len + 3);
        chk(mode == 4 ? "R9 single done" : "R4 single done", dones, 1);
        chk("R2 SDA released SCL held", pa, len);
        chk("R3 both released", pb, len + 3);
        chk("R4 SDA low SCL high", pc, len);
        chk("R4 pulls held after done", {30'd0, sda_pull, scl_pull}, 3);
        chk(mode == 3 ? "R7 no collision" : "R4 no collision", coll_at, -1);
      end
      1: begin
        chk("R5 collision time", coll_at, len + 3);
        chk("R5 no done", dones, 0);
        chk("R5 lines released idle", {29'd0, sda_pull, scl_pull, busy}, 0);
      end
      default: begin
        chk("R6 collision time", coll_at, len + 7);
        chk("R6 no done", dones, 0);
        chk("R6 lines released idle", {29'd0, sda_pull, scl_pull, busy}, 0);
      end
    endcase
    oth_sda = 1'b0;
    oth_scl = 1'b0;
    repeat (4) @(negedge clk);
    if (mode == 1 || mode == 2) begin
      repeat (8) @(negedge clk);
      chk("R8 flag sticky", 32'(coll_flag), 1);
      coll_clear = 1'b1;
      @(negedge clk);
      coll_clear = 1'b0;
      chk("R8 flag cleared", 32'(coll_flag), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {27'd0, sda_pull, scl_pull, done_pulse, coll_flag, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {27'd0, sda_pull, scl_pull, done_pulse, coll_flag, busy}, 0);
    for (int n = 0; n < (1 << RW); n++) run(n, 0);
    run(0, 1); run(1, 1); run(2, 1); run(5, 1); run(127, 1);
    run(5, 2); run(8, 2); run(30, 2); run(127, 2);
    run(1, 3); run(8, 3); run(64, 3);
    run(4, 4); run(20, 4);
    run(0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule